// File: doc/BRIEF.md
# BCD Time-of-Day Register File

This block is a calendar clock that keeps seconds, minutes, hours, weekday, day of month, month and a two-digit year, all in packed BCD. A one-cycle strobe at 1 Hz advances the count. Carries ripple from seconds up to the year, with month lengths taken into account and a leap February in every year divisible by four. Software reaches the clock through eight byte registers at the very top of a byte-addressed space, using a synchronous port with 8-bit data.

Every field write is masked to the bits that field uses and checked against the field's legal range. A value out of range is dropped without any side effect. The seconds register also holds a halt flag that freezes the count. The weekday register also holds a spare century flag. The control byte is stored with fixed bits forced. A register write in the same cycle as a tick cancels that tick, so a value software has just written is never advanced at once.

Top module: `tod_clock_regs`

## Requirements
- R1: After reset the registers read control 0x90, seconds 0x00 with the halt flag clear, minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01 and year 0x00.
- R2: The clock window is the eight highest addresses. Base = 2^ADDR_W - 8, and the offsets are 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday/century, 5 date, 6 month, 7 year. Read data appears on `rdata` one cycle after `addr` is presented. A read outside the window returns 0xFF, and a write outside the window changes nothing.
- R3: A seconds write takes bits 6:0 as BCD and is accepted only for 00–59 with both digits 0–9. Bit 7 is stored as the halt flag on every seconds write, whether or not the value is accepted. A seconds read returns the halt flag in bit 7 and the BCD seconds in bits 6:0.
- R4: While the halt flag is 1, ticks leave all time fields unchanged. After the flag is cleared, counting resumes from the held value.
- R5: A minutes write uses bits 6:0 and is accepted for BCD 00–59. An hours write uses bits 5:0 and is accepted for BCD 00–23. Rejected writes leave the field unchanged.
- R6: A date write uses bits 5:0 and is accepted for BCD 01–31, so zero is ignored. A month write uses bits 4:0 and is accepted for BCD 01–12. A year write uses all 8 bits and is accepted for BCD 00–99.
- R7: A weekday write stores bits 2:0 as the weekday and bit 6 as the century flag. A read returns the century flag in bit 6, ORed with the weekday in bits 2:0. All other bits read 0.
- R8: A control write stores (wdata & 0x5F) | 0x90. Bits 7 and 4 read 1 and bit 5 reads 0.
- R9: An accepted tick increments seconds. 59 seconds carries into minutes, 59 minutes carries into hours, and 23 hours carries into date and weekday. The weekday steps to 1 from 7 or above.
- R10: The date wraps to 01 when it has reached the month's length: 31, or 30 for months 4, 6, 9 and 11, or for month 2 either 29 when the year is divisible by 4 or 28 otherwise. The wrap then carries into the month.
- R11: Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R12: A write anywhere in the clock window in the same cycle as a tick takes effect, and that tick is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_1hz | input | 1 | One-cycle strobe that advances the clock by one second |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for the address of the previous cycle |

## Verification
A wrong carry or a wrong month length is not visible until a tick crosses the relevant boundary. It then shows up as a wrong date, month or year on the very next read. For this reason the directed cases place the clock one tick before each such boundary. A mishandled halt flag or tick priority shows as a seconds value that is off by one when read right after the tick cycle. A faulty range check leaves an illegal BCD value in a field, which is visible on the first read of that field and persists, and it also makes later roll-overs go wrong.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_SEC  = 3'd1;
  localparam logic [2:0] OFS_MIN  = 3'd2;
  localparam logic [2:0] OFS_HOUR = 3'd3;
  localparam logic [2:0] OFS_DOW  = 3'd4;
  localparam logic [2:0] OFS_DATE = 3'd5;
  localparam logic [2:0] OFS_MON  = 3'd6;
  localparam logic [2:0] OFS_YEAR = 3'd7;

  localparam logic [7:0] CTRL_RST = 8'h90;

  typedef struct packed {
    logic [7:0] ctrl;
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] dow;
    logic [7:0] date;
    logic [7:0] mon;
    logic [7:0] year;
    logic       halt;
    logic       cent;
  } tod_regs_t;

  typedef struct packed {
    logic ctrl;
    logic sec;
    logic min;
    logic hour;
    logic dow;
    logic date;
    logic mon;
    logic year;
  } tod_wen_t;

  // both digits decimal and value within [lo, hi] (BCD compares like binary)
  function automatic logic bcd_in_range(input logic [7:0] v,
                                        input logic [7:0] lo,
                                        input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = v + 8'd1;
    return r;
  endfunction

  // tens*10 is congruent to tens*2 modulo 4
  function automatic logic year_is_leap(input logic [7:0] y);
    logic [1:0] r;
    r = {y[4], 1'b0} + y[1:0];
    return r == 2'b00;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon,
                                           input logic [7:0] year);
    logic [7:0] r;
    case (mon)
      8'h02:                      r = year_is_leap(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tod_wr_check.sv
module tod_wr_check
  import tod_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              wr_hit,
  output tod_wen_t          wen,
  output tod_regs_t         wval
);

  localparam int HI_W = ADDR_W - 3;

  logic       in_win;
  logic [2:0] ofs;
  logic [7:0] v_sec, v_min, v_hour, v_date, v_mon;

  assign in_win = &addr[ADDR_W-1:ADDR_W-HI_W];
  assign ofs    = addr[2:0];
  assign wr_hit = wr_en && in_win;

  assign v_sec  = {1'b0, wdata[6:0]};
  assign v_min  = {1'b0, wdata[6:0]};
  assign v_hour = {2'b00, wdata[5:0]};
  assign v_date = {2'b00, wdata[5:0]};
  assign v_mon  = {3'b000, wdata[4:0]};

  always_comb begin
    wen = '0;
    if (wr_hit) begin
      case (ofs)
        OFS_CTRL: wen.ctrl = 1'b1;
        OFS_SEC:  wen.sec  = 1'b1;
        OFS_MIN:  wen.min  = bcd_in_range(v_min, 8'h00, 8'h59);
        OFS_HOUR: wen.hour = bcd_in_range(v_hour, 8'h00, 8'h23);
        OFS_DOW:  wen.dow  = 1'b1;
        OFS_DATE: wen.date = bcd_in_range(v_date, 8'h01, 8'h31);
        OFS_MON:  wen.mon  = bcd_in_range(v_mon, 8'h01, 8'h12);
        OFS_YEAR: wen.year = bcd_in_range(wdata, 8'h00, 8'h99);
        default:  wen = '0;
      endcase
    end
  end

  always_comb begin
    wval.ctrl = (wdata & 8'h5F) | 8'h90;
    // seconds value only used when legal; halt flag stored regardless
    wval.sec  = bcd_in_range(v_sec, 8'h00, 8'h59) ? v_sec : 8'hFF;
    wval.min  = v_min;
    wval.hour = v_hour;
    wval.dow  = {5'd0, wdata[2:0]};
    wval.date = v_date;
    wval.mon  = v_mon;
    wval.year = wdata;
    wval.halt = wdata[7];
    wval.cent = wdata[6];
  end

endmodule

// File: rtl/tod_time_chain.sv
module tod_time_chain
  import tod_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_1hz,
  input  logic      wr_hit,
  input  tod_wen_t  wen,
  input  tod_regs_t wval,
  output tod_regs_t cur_q
);

  tod_regs_t nxt;
  logic      adv, c_sec, c_min, c_hour, c_date, c_mon;
  logic      sec_ok;

  assign adv    = tick_1hz && !cur_q.halt && !wr_hit;
  assign c_sec  = adv && (cur_q.sec == 8'h59);
  assign c_min  = c_sec && (cur_q.min == 8'h59);
  assign c_hour = c_min && (cur_q.hour == 8'h23);
  assign c_date = c_hour && (cur_q.date >= month_len(cur_q.mon, cur_q.year));
  assign c_mon  = c_date && (cur_q.mon >= 8'h12);
  assign sec_ok = (wval.sec != 8'hFF);

  always_comb begin
    nxt = cur_q;
    // control
    if (wen.ctrl) nxt.ctrl = wval.ctrl;
    // seconds and halt flag
    if (wen.sec) begin
      nxt.halt = wval.halt;
      if (sec_ok) nxt.sec = wval.sec;
    end else if (adv) begin
      nxt.sec = c_sec ? 8'h00 : bcd_inc(cur_q.sec);
    end
    // minutes
    if (wen.min)        nxt.min = wval.min;
    else if (c_sec)     nxt.min = c_min ? 8'h00 : bcd_inc(cur_q.min);
    // hours
    if (wen.hour)       nxt.hour = wval.hour;
    else if (c_min)     nxt.hour = c_hour ? 8'h00 : bcd_inc(cur_q.hour);
    // weekday and century
    if (wen.dow) begin
      nxt.dow  = wval.dow;
      nxt.cent = wval.cent;
    end else if (c_hour) begin
      nxt.dow  = (cur_q.dow >= 8'd7) ? 8'd1 : cur_q.dow + 8'd1;
    end
    // date
    if (wen.date)       nxt.date = wval.date;
    else if (c_hour)    nxt.date = c_date ? 8'h01 : bcd_inc(cur_q.date);
    // month
    if (wen.mon)        nxt.mon = wval.mon;
    else if (c_date)    nxt.mon = c_mon ? 8'h01 : bcd_inc(cur_q.mon);
    // year
    if (wen.year)       nxt.year = wval.year;
    else if (c_mon)     nxt.year = (cur_q.year == 8'h99) ? 8'h00 : bcd_inc(cur_q.year);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q.ctrl <= CTRL_RST;
      cur_q.sec  <= 8'h00;
      cur_q.min  <= 8'h00;
      cur_q.hour <= 8'h00;
      cur_q.dow  <= 8'h01;
      cur_q.date <= 8'h01;
      cur_q.mon  <= 8'h01;
      cur_q.year <= 8'h00;
      cur_q.halt <= 1'b0;
      cur_q.cent <= 1'b0;
    end else begin
      cur_q <= nxt;
    end
  end

  a_r4_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q.halt && !wr_hit) |=> $stable(cur_q));

  a_r12_write_cancels_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && wr_hit && !wen.sec) |=> $stable(cur_q.sec));

  a_r3_sec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_in_range(cur_q.sec, 8'h00, 8'h59));

  a_r10_date_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_in_range(cur_q.date, 8'h01, 8'h31) && bcd_in_range(cur_q.mon, 8'h01, 8'h12));

  a_r8_ctrl_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q.ctrl[7] && cur_q.ctrl[4] && !cur_q.ctrl[5]);

  a_r9_sec_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cur_q.sec == 8'h00) |=> (cur_q.sec == 8'h01));

endmodule

// File: rtl/tod_rd_port.sv
module tod_rd_port
  import tod_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  tod_regs_t         cur,
  output logic [7:0]        rdata
);

  localparam int HI_W = ADDR_W - 3;

  logic       in_win;
  logic [7:0] rd_nxt;

  assign in_win = &addr[ADDR_W-1:ADDR_W-HI_W];

  always_comb begin
    rd_nxt = 8'hFF;
    if (in_win) begin
      case (addr[2:0])
        OFS_CTRL: rd_nxt = cur.ctrl;
        OFS_SEC:  rd_nxt = {cur.halt, cur.sec[6:0]};
        OFS_MIN:  rd_nxt = cur.min;
        OFS_HOUR: rd_nxt = cur.hour;
        OFS_DOW:  rd_nxt = {1'b0, cur.cent, 3'b000, cur.dow[2:0]};
        OFS_DATE: rd_nxt = cur.date;
        OFS_MON:  rd_nxt = cur.mon;
        OFS_YEAR: rd_nxt = cur.year;
        default:  rd_nxt = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= 8'h00;
    else        rdata <= rd_nxt;
  end

  a_r2_outside_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&addr[ADDR_W-1:3])) |=> (rdata == 8'hFF));

  a_r7_dow_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((&addr[ADDR_W-1:3]) && addr[2:0] == OFS_DOW) |=> (rdata[7] == 1'b0 && rdata[5:3] == 3'b000));

endmodule

// File: rtl/tod_clock_regs.sv
module tod_clock_regs
  import tod_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  localparam logic [ADDR_W-1:0] MIN_ADDR  = {{(ADDR_W-3){1'b1}}, OFS_MIN};
  localparam logic [ADDR_W-1:0] HOUR_ADDR = {{(ADDR_W-3){1'b1}}, OFS_HOUR};

  logic      wr_hit;
  tod_wen_t  wen;
  tod_regs_t wval;
  tod_regs_t cur;

  tod_wr_check #(.ADDR_W(ADDR_W)) u_wr (
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .wr_hit (wr_hit),
    .wen    (wen),
    .wval   (wval)
  );

  tod_time_chain u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .wr_hit   (wr_hit),
    .wen      (wen),
    .wval     (wval),
    .cur_q    (cur)
  );

  tod_rd_port #(.ADDR_W(ADDR_W)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .cur   (cur),
    .rdata (rdata)
  );

  a_r5_bad_minute_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == MIN_ADDR && wdata[6:0] > 7'h59) |=> $stable(cur.min));

  a_r5_bad_hour_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == HOUR_ADDR && wdata[5:0] > 6'h23) |=> $stable(cur.hour));

endmodule

// File: tb/test_tod_clock_regs.sv
module test_tod_clock_regs;

  localparam int AW = 13;
  localparam logic [AW-1:0] BASE = AW'((1 << AW) - 8);

  logic          clk, rst_n, tick_1hz, wr_en;
  logic [AW-1:0] addr;
  logic [7:0]    wdata, rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model, binary values
  int m_ctrl, m_s, m_m, m_h, m_dow, m_dt, m_mo, m_y, m_halt, m_cent;

  tod_clock_regs #(.ADDR_W(AW)) i_tod_clock_regs (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic int to_bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int from_bcd(input int v);
    return ((v >> 4) & 15) * 10 + (v & 15);
  endfunction

  function automatic bit legal(input int v, input int lo, input int hi);
    return ((v & 15) <= 9) && (((v >> 4) & 15) <= 9) &&
           (from_bcd(v) >= lo) && (from_bcd(v) <= hi);
  endfunction

  function automatic int days_of(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic void model_write(input int ofs, input int d);
    case (ofs)
      0: m_ctrl = (d & 8'h5F) | 8'h90;
      1: begin m_halt = (d >> 7) & 1; if (legal(d & 8'h7F, 0, 59)) m_s = from_bcd(d & 8'h7F); end
      2: if (legal(d & 8'h7F, 0, 59)) m_m = from_bcd(d & 8'h7F);
      3: if (legal(d & 8'h3F, 0, 23)) m_h = from_bcd(d & 8'h3F);
      4: begin m_dow = d & 7; m_cent = (d >> 6) & 1; end
      5: if (legal(d & 8'h3F, 1, 31)) m_dt = from_bcd(d & 8'h3F);
      6: if (legal(d & 8'h1F, 1, 12)) m_mo = from_bcd(d & 8'h1F);
      default: if (legal(d, 0, 99)) m_y = from_bcd(d);
    endcase
  endfunction

  function automatic void model_tick();
    m_s++;
    if (m_s < 60) return;
    m_s = 0; m_m++;
    if (m_m < 60) return;
    m_m = 0; m_h++;
    if (m_h < 24) return;
    m_h = 0;
    m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
    if (m_dt < days_of(m_mo, m_y)) begin m_dt++; return; end
    m_dt = 1;
    if (m_mo < 12) begin m_mo++; return; end
    m_mo = 1;
    m_y = (m_y == 99) ? 0 : m_y + 1;
  endfunction

  function automatic int model_read(input int ofs);
    case (ofs)
      0: return m_ctrl;
      1: return (m_halt << 7) | to_bcd(m_s);
      2: return to_bcd(m_m);
      3: return to_bcd(m_h);
      4: return (m_cent << 6) | m_dow;
      5: return to_bcd(m_dt);
      6: return to_bcd(m_mo);
      default: return to_bcd(m_y);
    endcase
  endfunction

  // called at a falling edge; one clock cycle
  task automatic step(input bit w, input int ofs, input int d, input bit t);
    wr_en = w; addr = BASE + AW'(ofs); wdata = 8'(d); tick_1hz = t;
    @(posedge clk);
    @(negedge clk);
    if (t && !w && m_halt == 0) model_tick();
    if (w) model_write(ofs, d);
    wr_en = 0; tick_1hz = 0;
  endtask

  task automatic compare(input string tag, input int ofs, input int exp);
    checks++;
    if (rdata !== 8'(exp)) begin
      errors++;
      $display("FAIL %s: offset %0d got %02h expected %02h", tag, ofs, rdata, 8'(exp));
    end
  endtask

  task automatic rd_chk(input string tag, input int ofs);
    wr_en = 0; tick_1hz = 0; addr = BASE + AW'(ofs);
    @(posedge clk);
    @(negedge clk);
    compare(tag, ofs, model_read(ofs));
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 8; i++) rd_chk(tag, i);
  endtask

  task automatic set_time(input int y, input int mo, input int dt,
                          input int h, input int mi, input int s, input int dw);
    step(1, 7, to_bcd(y), 0);
    step(1, 6, to_bcd(mo), 0);
    step(1, 5, to_bcd(dt), 0);
    step(1, 4, dw, 0);
    step(1, 3, to_bcd(h), 0);
    step(1, 2, to_bcd(mi), 0);
    step(1, 1, to_bcd(s), 0);
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; tick_1hz = 0; addr = '0; wdata = '0;
    m_ctrl = 8'h90; m_s = 0; m_m = 0; m_h = 0; m_dow = 1; m_dt = 1;
    m_mo = 1; m_y = 0; m_halt = 0; m_cent = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset values
    check_all("R1");

    // R8 control forced bits
    step(1, 0, 8'hFF, 0); rd_chk("R8", 0);
    step(1, 0, 8'h00, 0); rd_chk("R8", 0);
    step(1, 0, 8'h2A, 0); rd_chk("R8", 0);

    // R3 seconds range, halt flag stored even on rejected value
    step(1, 1, 8'h5A, 0); rd_chk("R3", 1);
    step(1, 1, 8'h60, 0); rd_chk("R3", 1);
    step(1, 1, 8'h45, 0); rd_chk("R3", 1);
    step(1, 1, 8'hE0, 0); rd_chk("R3", 1);
    step(1, 1, 8'hC5, 0); rd_chk("R3", 1);

    // R4 halted clock ignores ticks, then resumes
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1);
    rd_chk("R4", 1);
    step(1, 1, 8'h45, 0);
    step(0, 0, 0, 1);
    rd_chk("R4", 1);

    // R5 minutes and hours
    step(1, 2, 8'h60, 0); rd_chk("R5", 2);
    step(1, 2, 8'h59, 0); rd_chk("R5", 2);
    step(1, 3, 8'h24, 0); rd_chk("R5", 3);
    step(1, 3, 8'h1A, 0); rd_chk("R5", 3);
    step(1, 3, 8'hE3, 0); rd_chk("R5", 3);

    // R6 date, month, year
    step(1, 5, 8'h00, 0); rd_chk("R6", 5);
    step(1, 5, 8'h32, 0); rd_chk("R6", 5);
    step(1, 5, 8'hF1, 0); rd_chk("R6", 5);
    step(1, 6, 8'h13, 0); rd_chk("R6", 6);
    step(1, 6, 8'h00, 0); rd_chk("R6", 6);
    step(1, 6, 8'h12, 0); rd_chk("R6", 6);
    step(1, 7, 8'h9A, 0); rd_chk("R6", 7);
    step(1, 7, 8'h99, 0); rd_chk("R6", 7);

    // R7 weekday with century flag
    step(1, 4, 8'hFF, 0); rd_chk("R7", 4);
    step(1, 4, 8'h05, 0); rd_chk("R7", 4);

    // R9 and R11 full roll-over at end of year 99
    set_time(99, 12, 31, 23, 59, 59, 7);
    step(0, 0, 0, 1);
    check_all("R11");

    // R9 minute carry
    set_time(10, 6, 15, 10, 14, 59, 3);
    step(0, 0, 0, 1);
    check_all("R9");

    // R10 month lengths and leap years
    set_time(23, 2, 28, 23, 59, 59, 2); step(0, 0, 0, 1); check_all("R10");
    set_time(24, 2, 28, 23, 59, 59, 2); step(0, 0, 0, 1); check_all("R10");
    set_time(24, 2, 29, 23, 59, 59, 2); step(0, 0, 0, 1); check_all("R10");
    set_time(30, 4, 30, 23, 59, 59, 6); step(0, 0, 0, 1); check_all("R10");
    set_time(31, 1, 31, 23, 59, 59, 1); step(0, 0, 0, 1); check_all("R10");

    // R12 write in the tick cycle wins; tick lost
    set_time(5, 5, 5, 5, 5, 30, 4);
    step(1, 2, 8'h20, 1);
    rd_chk("R12", 1); rd_chk("R12", 2);

    // R2 outside window
    addr = '0; @(posedge clk); @(negedge clk);
    compare("R2", -1, 8'hFF);
    wr_en = 1; addr = AW'(5); wdata = 8'h00; @(posedge clk); @(negedge clk); wr_en = 0;
    wr_en = 1; addr = BASE - AW'(1); wdata = 8'h00; @(posedge clk); @(negedge clk); wr_en = 0;
    check_all("R2");

    // random mix
    process::self().srandom(32'h1D5);
    for (int n = 0; n < 800; n++) begin
      int op, ofs, d;
      op  = $urandom_range(0, 9);
      ofs = $urandom_range(0, 7);
      d   = $urandom_range(0, 255);
      if ($urandom_range(0, 1) == 1) d = to_bcd($urandom_range(0, 59)) | (d & 8'h80);
      if (ofs == 1 && $urandom_range(0, 3) != 0) d = d & 8'h7F;
      if (op < 6)      step(0, 0, 0, 1);
      else if (op < 8) step(1, ofs, d, 0);
      else             step(1, ofs, d, 1);
      if (n % 25 == 24) check_all("R9 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule